// File: doc/BRIEF.md
# Byte-Wide Memory with Single-Error-Correcting Check Bits

This block is a small, clocked model of a byte-wide static memory that keeps four hidden check bits beside every stored byte. Its control inputs are the active-low chip-select, output-enable and write-enable strobes of an asynchronous memory, sampled on each rising clock edge. A write encodes the byte into a 12-bit Hamming codeword and stores it. A read recomputes the syndrome, repairs a single flipped bit on the way out and flags what it found. Nothing outside the block can see or write the check bits. The data port stays eight bits wide, so the block can take the place of a memory that has no protection.

The check bits sit at codeword positions 1, 2, 4 and 8. The data bits fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order, from data bit 0 up to data bit 7. Bit i of a codeword vector is position i+1. A test mask can be XORed into the codeword as it is stored, so that single and double faults can be planted. Correction acts only on the returned value. The stored word is never written back.

Top module: `ecc_byte_ram`

## Requirements
- R1: A write happens when ce_n and we_n are both low at a rising edge. It stores the codeword for din at addr. Check bit k (at position 2^k) is the even parity of every other position whose index has bit k set.
- R2: A read happens when ce_n and oe_n are low and we_n is high at a rising edge. After that edge, dout_en is 1 and dout holds the stored byte. When the word is fault-free, err_fix and err_bad are 0.
- R3: If one data bit of the stored codeword is flipped, the read returns the original byte and err_fix is 1.
- R4: While ce_n is high there is no access: the memory contents do not change, and after the edge dout_en is 0 and dout is 0.
- R5: On a write edge the output is disabled: after that edge dout_en, err_fix and err_bad are 0.
- R6: If one check bit (position 1, 2, 4 or 8) is flipped, the read returns the stored byte unchanged and err_fix is 1.
- R7: A syndrome of 13, 14 or 15 sets err_bad to 1 and err_fix to 0. The data bits are returned as stored, without any change.
- R8: Correction is not written back. Reading a faulty word again reports the same flag and returns the same corrected data.
- R9: A read with oe_n high drives no output (dout_en and dout are 0) and raises no flag.
- R10: While rst_n is low the outputs are 0 and every address holds the all-zero codeword. Reads after reset return 0 with no flag.
- R11: Bit i of inj_mask is XORed into codeword position i+1 on a write. A double fault whose syndrome lies in 1..12 is treated as a single fault and is miscorrected at that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | 8 | Write data |
| inj_mask | input | 12 | Fault mask XORed into the stored codeword |
| dout | output | 8 | Read data (0 when not driven) |
| dout_en | output | 1 | Output drive enable, standing in for the high-impedance control |
| err_fix | output | 1 | The last read corrected a single-bit error |
| err_bad | output | 1 | The last read saw an uncorrectable syndrome |

## Verification
A fault planted by a write and its repair on a read can fall on back-to-back edges at the same address. A read in the cycle before a write also leaves its result on the port while the write edge clears it. The bench provokes both cases by issuing a write with a mask to an address and reading that address on the very next edge. It also reads an address and writes it on the next edge. On every clock a behavioural reference model predicts the data, drive enable and flags, and the bench compares them against the port.

// File: rtl/ecc_byte_ram.sv
module ecc_byte_ram #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [11:0]       inj_mask,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              err_fix,
  output logic              err_bad
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = 8;
  localparam int PW    = 4;
  localparam int CW    = DW + PW;

  logic [CW-1:0] mem [DEPTH];

  function automatic logic [PW-1:0] syndrome(input logic [CW-1:0] c);
    logic [PW-1:0] s;
    s = '0;
    for (int p = 1; p <= CW; p++)
      for (int k = 0; k < PW; k++)
        if (p[k]) s[k] = s[k] ^ c[p-1];
    return s;
  endfunction

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic [2:0] j;
    logic [PW-1:0] s;
    c = '0;
    j = '0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        c[p-1] = d[j];
        j = j + 3'd1;
      end
    s = syndrome(c);
    for (int k = 0; k < PW; k++) c[(1 << k) - 1] = s[k];
    return c;
  endfunction

  function automatic logic [DW-1:0] extract(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    logic [2:0] j;
    d = '0;
    j = '0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        d[j] = c[p-1];
        j = j + 3'd1;
      end
    return d;
  endfunction

  wire wr = !ce_n && !we_n;
  wire rd = !ce_n && we_n && !oe_n;

  logic [CW-1:0] raw_cw, fixed_cw;
  logic [PW-1:0] syn;
  logic          fix, bad;

  always_comb begin
    raw_cw   = mem[addr];
    syn      = syndrome(raw_cw);
    fix      = (syn != '0) && (syn <= PW'(CW));
    bad      = (syn > PW'(CW));
    fixed_cw = fix ? (raw_cw ^ (CW'(1) << (syn - PW'(1)))) : raw_cw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      dout    <= '0;
      dout_en <= 1'b0;
      err_fix <= 1'b0;
      err_bad <= 1'b0;
    end else begin
      if (wr) mem[addr] <= encode(din) ^ inj_mask;
      dout_en <= rd;
      dout    <= rd ? extract(fixed_cw) : '0;
      err_fix <= rd && fix;
      err_bad <= rd && bad;
    end
  end

  assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!dout_en && dout == '0));

  assert_write_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> (!dout_en && !err_fix && !err_bad));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_fix && err_bad));

  assert_oe_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && oe_n) |=> (!dout_en && !err_fix && !err_bad));

  assert_flag_needs_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_fix || err_bad) |-> dout_en);
endmodule

// File: tb/ecc_byte_ram_test.sv
module ecc_byte_ram_test;
  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [3:0] addr = 0;
  logic [7:0] din = 0;
  logic [11:0] inj_mask = 0;
  logic [7:0] dout;
  logic dout_en, err_fix, err_bad;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R10", exp_tag = "R10";
  logic [11:0] mm [16];
  logic [7:0] e_dout = 0;
  logic e_en = 0, e_fix = 0, e_bad = 0;

  ecc_byte_ram #(.ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .inj_mask(inj_mask),
    .dout(dout), .dout_en(dout_en), .err_fix(err_fix), .err_bad(err_bad));

  always #4 clk = ~clk;

  function automatic logic [11:0] ref_enc(input logic [7:0] d);
    logic [11:0] c;
    c = {d[7], d[6], d[5], d[4], 1'b0, d[3], d[2], d[1], 1'b0, d[0], 2'b00};
    c[0] = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c[1] = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c[3] = d[1] ^ d[2] ^ d[3] ^ d[7];
    c[7] = d[4] ^ d[5] ^ d[6] ^ d[7];
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mm[i] = 0;
      e_dout = 0; e_en = 0; e_fix = 0; e_bad = 0;
      exp_tag = "R10";
    end else begin
      logic [11:0] c;
      int s;
      exp_tag = tag;
      e_en = 0; e_fix = 0; e_bad = 0; e_dout = 0;
      if (!ce_n && !we_n) mm[addr] = ref_enc(din) ^ inj_mask;
      else if (!ce_n && !oe_n) begin
        c = mm[addr];
        s = 0;
        for (int p = 1; p <= 12; p++) if (c[p-1]) s = s ^ p;
        if (s >= 1 && s <= 12) begin c[s-1] = ~c[s-1]; e_fix = 1; end
        else if (s > 12) e_bad = 1;
        e_en = 1;
        e_dout = {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
      end
    end
  end

  always @(negedge clk) if (!done) begin
    checks++;
    if (dout !== e_dout || dout_en !== e_en || err_fix !== e_fix || err_bad !== e_bad) begin
      errors++;
      $display("FAIL %s: dout=%h en=%b fix=%b bad=%b, expected dout=%h en=%b fix=%b bad=%b",
               exp_tag, dout, dout_en, err_fix, err_bad, e_dout, e_en, e_fix, e_bad);
    end
  end

  task automatic op(input logic c, input logic o, input logic w, input logic [3:0] a,
                    input logic [7:0] d, input logic [11:0] m, input string t);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = a; din = d; inj_mask = m; tag = t;
  endtask
  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic [11:0] m, input string t);
    op(0, 1, 0, a, d, m, t);
  endtask
  task automatic rd(input logic [3:0] a, input string t);
    op(0, 0, 1, a, 8'h00, 12'h000, t);
  endtask
  task automatic idle(input string t);
    op(1, 1, 1, 4'd0, 8'h00, 12'h000, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(4'd3, "R10"); rd(4'd15, "R10");
    wr(4'd1, 8'hA5, 0, "R1"); rd(4'd1, "R1");
    wr(4'd7, 8'hFF, 0, "R2"); wr(4'd8, 8'h00, 0, "R2"); wr(4'd9, 8'h5A, 0, "R2");
    rd(4'd7, "R2"); rd(4'd8, "R2"); rd(4'd9, "R2");
    wr(4'd2, 8'h3C, 12'h020, "R3"); rd(4'd2, "R3");
    rd(4'd2, "R8"); idle("R8"); rd(4'd2, "R8");
    wr(4'd10, 8'hC3, 12'h800, "R3"); rd(4'd10, "R3");
    wr(4'd4, 8'h81, 12'h008, "R6"); rd(4'd4, "R6");
    wr(4'd11, 8'h6E, 12'h001, "R6"); rd(4'd11, "R6");
    wr(4'd5, 8'h96, 12'h090, "R7"); rd(4'd5, "R7"); rd(4'd5, "R8");
    wr(4'd6, 8'h00, 12'h003, "R11"); rd(4'd6, "R11");
    op(1, 1, 0, 4'd1, 8'hFF, 12'h000, "R4"); op(1, 0, 1, 4'd1, 8'h00, 0, "R4");
    rd(4'd1, "R4");
    op(0, 1, 1, 4'd1, 8'h00, 0, "R9"); idle("R9");
    rd(4'd7, "R5"); wr(4'd7, 8'h12, 0, "R5"); rd(4'd7, "R5");
    op(0, 0, 0, 4'd12, 8'h77, 0, "R5"); rd(4'd12, "R5");
    idle("R5"); idle("R5");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule